// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small CPU core and decides which of five interrupt sources gets serviced next. The sources are two external pins, two timer overflow events and one serial-port request. Each source has its own enable bit and its own priority bit, and a global enable gates all of them. When the core signals an instruction boundary and an eligible request exists, the block emits a one-cycle take pulse with the fixed vector address of the winning source. The core uses that pulse to push its program counter and jump to the vector.

The block keeps track of which priority levels currently have a handler running, so handlers can nest. A high-level request can interrupt a low-level handler. A low-level request waits until every handler has returned, and a high-level request waits while another high-level handler is active. A return strobe from the core retires the innermost active level and produces a one-cycle pop pulse, which tells the core to restore its program counter.

Each external pin is active low and has two modes. In edge mode, a falling edge sets a sticky flag. In level mode, the flag follows the pin. The hardware clears edge flags and timer flags when it takes their vector. The serial request is a level driven by the serial port, and the controller never clears it.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset, `take` and `pc_pop` are low, `vec_addr` is 0, `in_service` is 00, and every source flag is clear.
- R2: Source index i has vector address 8*i+3. The index order is external0=0, timer0=1, external1=2, timer1=3, serial=4, which gives 03h, 0Bh, 13h, 1Bh and 23h. `vec_addr` holds the last taken vector.
- R3: A pending source is taken only when its bit in `src_en` (bit i for index i) and `glb_en` are both 1.
- R4: A take happens only in the cycle after a clock edge where `insn_bound` was 1. A pending request without that strobe produces no take.
- R5: A source whose `src_hi` bit is 1 belongs to the high level. An eligible high-level request wins over any low-level one, whatever their indices.
- R6: Among eligible requests of the same level, the lowest index wins.
- R7: `in_service` bit 1 marks an active high-level handler and bit 0 an active low-level one. A take sets the bit of its level. A high-level request is taken only when bit 1 is 0. A low-level request is taken only when both bits are 0.
- R8: A `reti` strobe clears bit 1 if it is set, and otherwise clears bit 0. In the next cycle `pc_pop` pulses, but only if a level was active.
- R9: When `ext_edge[p]` is 1, a 1-to-0 transition on `ext_pin_n[p]` latches a request that is cleared when its vector is taken. When `ext_edge[p]` is 0, the request follows the low pin and is not cleared by a take.
- R10: A one-cycle `tmr_ovf[p]` pulse latches a request that stays pending until its vector is taken.
- R11: The serial request follows `ser_req`. Taking it does not clear it, so it is taken again after return while `ser_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| ext_edge | input | 2 | Per pin: 1 = falling-edge mode, 0 = level mode |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Serial receive/transmit request level |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enable, bit i = source index i |
| src_hi | input | 5 | Per-source high-priority select, bit i = source index i |
| insn_bound | input | 1 | Instruction-boundary strobe from the core |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| take | output | 1 | One-cycle pulse: push PC and jump to vec_addr |
| vec_addr | output | 8 | Vector address of the last taken interrupt |
| in_service | output | 2 | Active handler levels (bit 1 high, bit 0 low) |
| pc_pop | output | 1 | One-cycle pulse: restore PC from the stack |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each rising edge. They also assume that `reti` arrives only as a single-cycle strobe from a core that is leaving a handler. They do not assume the two strobes are mutually exclusive. However, the bench changes every input only on the falling clock edge and never raises `insn_bound` and `reti` in the same cycle. This keeps nesting depth changes unambiguous and lets each take be traced to one boundary.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_TMR = 2'd1,
    SRC_SER = 2'd2
  } src_kind_e;

  // Sources interleave pin and timer, with the serial source last.
  function automatic src_kind_e src_kind(input int idx, input int nsrc);
    if (idx == nsrc - 1) return SRC_SER;
    else if ((idx % 2) == 0) return SRC_EXT;
    else return SRC_TMR;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank import irq_pkg::*; #(
  parameter int N_PAIR = 2,
  parameter int NSRC   = 2 * N_PAIR + 1,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PAIR-1:0] ext_pin_n,
  input  logic [N_PAIR-1:0] ext_edge,
  input  logic [N_PAIR-1:0] tmr_ovf,
  input  logic              ser_req,
  input  logic              fire,
  input  logic [IDX_W-1:0]  fire_idx,
  output logic [NSRC-1:0]   pend
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int P = i / 2;
    logic flag_q;
    logic hit;

    assign hit     = fire && (fire_idx == IDX_W'(i));
    assign pend[i] = flag_q;

    if (src_kind(i, NSRC) == SRC_SER) begin : g_ser
      always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= ser_req;
      end
    end else if (src_kind(i, NSRC) == SRC_EXT) begin : g_ext
      logic pin_d;
      always_ff @(posedge clk) begin
        if (rst) begin
          pin_d  <= 1'b1;
          flag_q <= 1'b0;
        end else begin
          pin_d <= ext_pin_n[P];
          if (!ext_edge[P])                  flag_q <= ~ext_pin_n[P];
          else if (pin_d && !ext_pin_n[P])   flag_q <= 1'b1;
          else if (hit)                      flag_q <= 1'b0;
        end
      end
    end else begin : g_tmr
      always_ff @(posedge clk) begin
        if (rst)             flag_q <= 1'b0;
        else if (tmr_ovf[P]) flag_q <= 1'b1;
        else if (hit)        flag_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NSRC  = 5,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glb_en,
  input  logic             act_hi,
  input  logic             act_lo,
  output logic             req_valid,
  output logic             req_hi,
  output logic [IDX_W-1:0] req_idx
);

  logic [NSRC-1:0] elig, hi_cand, lo_cand, pick;

  always_comb begin
    elig    = pend & src_en & {NSRC{glb_en}};
    hi_cand = elig &  src_hi & {NSRC{~act_hi}};
    lo_cand = elig & ~src_hi & {NSRC{~act_hi & ~act_lo}};
    req_hi  = |hi_cand;
    pick    = req_hi ? hi_cand : lo_cand;
    req_valid = |pick;
    req_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pick[i]) req_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_level_track.sv
`timescale 1ns/1ps
module irq_level_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       grant,
  input  logic       grant_hi,
  input  logic       ret,
  output logic [1:0] act,
  output logic       pop
);

  logic [1:0] act_nx;

  always_comb begin
    act_nx = act;
    if (ret) begin
      if (act[1]) act_nx[1] = 1'b0;
      else        act_nx[0] = 1'b0;
    end
    if (grant) begin
      if (grant_hi) act_nx[1] = 1'b1;
      else          act_nx[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 2'b00;
      pop <= 1'b0;
    end else begin
      act <= act_nx;
      pop <= ret && (act != 2'b00);
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl import irq_pkg::*; #(
  parameter int N_PAIR   = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PAIR-1:0]   ext_pin_n,
  input  logic [N_PAIR-1:0]   ext_edge,
  input  logic [N_PAIR-1:0]   tmr_ovf,
  input  logic                ser_req,
  input  logic                glb_en,
  input  logic [2*N_PAIR:0]   src_en,
  input  logic [2*N_PAIR:0]   src_hi,
  input  logic                insn_bound,
  input  logic                reti,
  output logic                take,
  output logic [VEC_W-1:0]    vec_addr,
  output logic [1:0]          in_service,
  output logic                pc_pop
);

  localparam int NSRC  = 2 * N_PAIR + 1;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  pend;
  logic             req_valid, req_hi, fire;
  logic [IDX_W-1:0] req_idx;
  logic [VEC_W-1:0] vec_c;

  irq_flag_bank #(.N_PAIR(N_PAIR), .NSRC(NSRC), .IDX_W(IDX_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .ext_pin_n(ext_pin_n),
    .ext_edge (ext_edge),
    .tmr_ovf  (tmr_ovf),
    .ser_req  (ser_req),
    .fire     (fire),
    .fire_idx (req_idx),
    .pend     (pend)
  );

  irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .pend     (pend),
    .src_en   (src_en),
    .src_hi   (src_hi),
    .glb_en   (glb_en),
    .act_hi   (in_service[1]),
    .act_lo   (in_service[0]),
    .req_valid(req_valid),
    .req_hi   (req_hi),
    .req_idx  (req_idx)
  );

  irq_level_track u_lvl (
    .clk     (clk),
    .rst     (rst),
    .grant   (fire),
    .grant_hi(req_hi),
    .ret     (reti),
    .act     (in_service),
    .pop     (pc_pop)
  );

  assign fire  = insn_bound && req_valid;
  assign vec_c = VEC_W'(VEC_BASE) + VEC_W'(req_idx) * VEC_W'(VEC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      vec_addr <= '0;
    end else begin
      take <= fire;
      if (fire) vec_addr <= vec_c;
    end
  end

endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
  parameter int N_PAIR   = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_bound,
  input logic             reti,
  input logic             glb_en,
  input logic             take,
  input logic [VEC_W-1:0] vec_addr,
  input logic [1:0]       in_service,
  input logic             pc_pop
);

  localparam int NSRC = 2 * N_PAIR + 1;

  p_vec_slot_r2: assert property (@(posedge clk) disable iff (rst)
    take |-> (int'(vec_addr) >= VEC_BASE) &&
             (((int'(vec_addr) - VEC_BASE) % VEC_STEP) == 0) &&
             (int'(vec_addr) < VEC_BASE + NSRC * VEC_STEP));

  p_take_gen_r3: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(glb_en));

  p_take_bound_r4: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(insn_bound));

  p_hi_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> !$past(in_service[1]));

  p_take_moves_level_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> (in_service != $past(in_service)));

  p_rise_from_take_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_service[1]) || $rose(in_service[0])) |-> take);

  p_pop_cause_r8: assert property (@(posedge clk) disable iff (rst)
    pc_pop |-> $past(reti) && ($past(in_service) != 2'b00));

  p_lo_drop_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(in_service[0]) |-> $past(reti) && !$past(in_service[1]));

endmodule

bind irq_ctrl irq_ctrl_chk #(
  .N_PAIR(N_PAIR), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .insn_bound(insn_bound),
  .reti      (reti),
  .glb_en    (glb_en),
  .take      (take),
  .vec_addr  (vec_addr),
  .in_service(in_service),
  .pc_pop    (pc_pop)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_pin_n = 2'b11;
  logic [1:0] ext_edge  = 2'b11;
  logic [1:0] tmr_ovf   = 2'b00;
  logic       ser_req   = 1'b0;
  logic       glb_en    = 1'b0;
  logic [4:0] src_en    = 5'b0;
  logic [4:0] src_hi    = 5'b0;
  logic       insn_bound = 1'b0;
  logic       reti       = 1'b0;
  logic       take;
  logic [7:0] vec_addr;
  logic [1:0] in_service;
  logic       pc_pop;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .ser_req(ser_req), .glb_en(glb_en), .src_en(src_en),
    .src_hi(src_hi), .insn_bound(insn_bound), .reti(reti), .take(take),
    .vec_addr(vec_addr), .in_service(in_service), .pc_pop(pc_pop)
  );

  // Behavioural reference model
  int m_flag [5];
  bit m_pind [2];
  bit m_hi, m_lo, m_take, m_pop;
  int m_vec;

  always @(posedge clk) begin
    int w;
    bit wl, ohi, olo;
    if (rst) begin
      foreach (m_flag[k]) m_flag[k] = 0;
      m_pind[0] = 1; m_pind[1] = 1;
      m_hi = 0; m_lo = 0; m_take = 0; m_pop = 0; m_vec = 0;
    end else begin
      w = -1; wl = 0; ohi = m_hi; olo = m_lo;
      if (glb_en && !ohi)
        for (int i = 4; i >= 0; i--)
          if (m_flag[i] != 0 && src_en[i] && src_hi[i]) begin w = i; wl = 1; end
      if (w < 0 && glb_en && !ohi && !olo)
        for (int i = 4; i >= 0; i--)
          if (m_flag[i] != 0 && src_en[i] && !src_hi[i]) begin w = i; wl = 0; end
      m_take = insn_bound && (w >= 0);
      m_pop  = reti && (ohi || olo);
      if (reti) begin
        if (ohi) m_hi = 0; else m_lo = 0;
      end
      if (m_take) begin
        if (wl) m_hi = 1; else m_lo = 1;
        m_vec = 8 * w + 3;
        if (w != 4) m_flag[w] = 0;
      end
      for (int p = 0; p < 2; p++) begin
        if (!ext_edge[p]) m_flag[2*p] = !ext_pin_n[p];
        else if (m_pind[p] && !ext_pin_n[p]) m_flag[2*p] = 1;
        m_pind[p] = ext_pin_n[p];
        if (tmr_ovf[p]) m_flag[2*p+1] = 1;
      end
      m_flag[4] = ser_req;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 take vs model", int'(take), int'(m_take));
      chk("R2 vector vs model", int'(vec_addr), m_vec);
      chk("R7 in_service vs model", int'(in_service), int'({m_hi, m_lo}));
      chk("R8 pop vs model", int'(pc_pop), int'(m_pop));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fire();
    insn_bound = 1'b1; tick(); insn_bound = 1'b0;
  endtask

  task automatic ret();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 take", int'(take), 0);
    chk("R1 vec", int'(vec_addr), 0);
    chk("R1 in_service", int'(in_service), 0);
    chk("R1 pop", int'(pc_pop), 0);
    tick();

    // R3 / R10: timer0 flag gated by enables
    tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0;
    src_en = 5'b00010; glb_en = 1'b0;
    fire(); chk("R3 global off", int'(take), 0);
    glb_en = 1'b1; src_en = 5'b00000;
    fire(); chk("R3 source off", int'(take), 0);
    src_en = 5'b00010;
    fire(); chk("R3 take", int'(take), 1);
    chk("R2 timer0 vector", int'(vec_addr), 8'h0B);
    chk("R7 low level set", int'(in_service), 1);
    tick(); chk("R4 single pulse", int'(take), 0);
    ret(); chk("R8 pop", int'(pc_pop), 1);
    chk("R8 level cleared", int'(in_service), 0);
    fire(); chk("R10 flag cleared by take", int'(take), 0);

    // R6 / R9 / R7: ext1 edge and timer1 together at low level
    src_en = 5'b11111;
    ext_pin_n[1] = 1'b0; tmr_ovf[1] = 1'b1; tick();
    tmr_ovf[1] = 1'b0; ext_pin_n[1] = 1'b1;
    fire(); chk("R6 lower index first", int'(vec_addr), 8'h13);
    fire(); chk("R7 low blocked by low", int'(take), 0);
    ret();
    fire(); chk("R6 timer1 next", int'(vec_addr), 8'h1B);
    chk("R10 timer1 taken", int'(take), 1);
    ret();
    fire(); chk("R9 edge flag cleared", int'(take), 0);

    // R5 / R11 / R7 / R8
    src_hi = 5'b10000; ser_req = 1'b1; tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0;
    fire(); chk("R5 high beats low", int'(vec_addr), 8'h23);
    chk("R5 high level set", int'(in_service), 2);
    fire(); chk("R7 high blocks all", int'(take), 0);
    ret();
    fire(); chk("R11 serial retaken", int'(vec_addr), 8'h23);
    chk("R11 take", int'(take), 1);
    ser_req = 1'b0; tick();
    ret();
    fire(); chk("R6 timer0 after serial", int'(vec_addr), 8'h0B);
    ser_req = 1'b1; tick();
    fire(); chk("R7 preempt vector", int'(vec_addr), 8'h23);
    chk("R7 nested levels", int'(in_service), 3);
    ser_req = 1'b0;
    ret(); chk("R8 inner level retired", int'(in_service), 1);
    chk("R8 pop nested", int'(pc_pop), 1);
    ret(); chk("R8 outer level retired", int'(in_service), 0);

    // R9 level mode on external 0
    ext_edge[0] = 1'b0; ext_pin_n[0] = 1'b0; tick();
    fire(); chk("R9 level taken", int'(vec_addr), 8'h03);
    ret();
    fire(); chk("R9 level not cleared", int'(take), 1);
    ext_pin_n[0] = 1'b1;
    ret(); tick();
    fire(); chk("R9 level follows pin", int'(take), 0);

    // R8 return with nothing active
    ret(); chk("R8 idle pop", int'(pc_pop), 0);

    // R4 no boundary, no take
    tmr_ovf[1] = 1'b1; tick(); tmr_ovf[1] = 1'b0;
    tick(); tick();
    chk("R4 waits for boundary", int'(take), 0);
    fire(); chk("R4 taken at boundary", int'(vec_addr), 8'h1B);
    ret();
    tick();
    finish_run();
  end

endmodule